// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked master for an external asynchronous static RAM of 131,072 bytes, with a 17-bit address and 8-bit data. An internal requester presents a request with an address, a write flag and write data, and holds it until a one-cycle acknowledge. The controller then produces the memory strobes: an active-low primary select, an active-high secondary select, an active-low write strobe and an active-low output-enable. It also drives the address, the outgoing data and the enable of the data-bus tri-state driver, and it returns the byte read from the memory.

All timing is sized in whole clock cycles. Each nanosecond limit is turned into a cycle count, rounded up, with a floor of one cycle. The read phase covers both the address access time and the output-enable access time. The write phase covers the write-pulse width, the select-to-end and address-to-end windows, and the data-setup window. After a read, the memory may go on driving the shared bus for a short time. For this reason a write that follows a read waits out a float interval before the controller turns its data driver on.

Top module: `sram_async_ctrl`

## Requirements
- R1: While no transaction is active, and during reset, the primary select is 1, the secondary select is 0, the write strobe is 1, the output-enable is 1, the data driver enable is 0 and the acknowledge is 0.
- R2: A read holds the primary select at 0, the secondary select at 1, the output-enable at 0 and the write strobe at 1, with the requested address on the memory address pins. It lasts exactly RD cycles, where RD is the larger of ceil(T_AA_NS/CLK_PERIOD_NS) and ceil(T_OE_NS/CLK_PERIOD_NS), and at least 1 (15 with the default parameters).
- R3: The read result is the value on the memory data input during the last read cycle. It is presented on `rdata` in the acknowledge cycle and held until the next read completes.
- R4: A write holds the primary select at 0, the secondary select at 1, the write strobe at 0 and the output-enable at 1, with the address and data stable. It lasts exactly WR cycles, the largest of the rounded-up write-pulse, select-to-end, address-to-end and data-setup limits, and at least 1 (13 with the defaults).
- R5: The data driver enable is 1 in exactly the cycles in which the write strobe is 0. It falls in the same cycle in which the write strobe rises.
- R6: The acknowledge is a single-cycle pulse in the first idle cycle after every transaction and at no other time. A request seen during the acknowledge cycle is not started. With a request held continuously, the next transaction therefore starts after exactly 2 idle cycles, unless R7 applies.
- R7: A write that directly follows a read starts only after FL+1 idle cycles, where FL is ceil(T_FLOAT_NS/CLK_PERIOD_NS) with a floor of 1 (6 idle cycles with the defaults). The output-enable is high for at least FL cycles before the data driver turns on.
- R8: The address, the write flag and the write data are captured when a transaction starts. Changes on the request inputs during the transaction do not affect the memory address or the outgoing data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid, held until acknowledge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Request write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Primary select, active low |
| mem_cs2 | output | 1 | Secondary select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The strobes change on the first clock edge after the request is accepted and stay unchanged for RD or WR cycles. The acknowledge and the captured read byte both appear in the first idle cycle after that, and the next start comes 2 idle cycles later, or FL+1 idle cycles later for a write after a read. The bench samples on the falling clock edge and measures the length of every active run and every idle gap against these counts, which it computes from the nanosecond parameters. Its memory model puts the correct byte on the data input only in the expected last read cycle, so a capture that is one cycle early or one cycle late returns a wrong value.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  // Rounded-up conversion of a nanosecond limit to clock cycles, never below one.
  function automatic int unsigned cycles_for(int unsigned lim_ns, int unsigned per_ns);
    int unsigned c;
    c = (lim_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sramc_downctr.sv
module sramc_downctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   req_we,
  input  logic   phase_zero,
  input  logic   gap_zero,
  output phase_e phase,
  output logic   start_rd,
  output logic   start_wr,
  output logic   phase_done,
  output logic   ack
);
  phase_e ph_q;
  logic   ack_q;

  // A request is not taken during the acknowledge cycle.
  assign start_rd   = (ph_q == PH_IDLE) && req && !ack_q && !req_we;
  assign start_wr   = (ph_q == PH_IDLE) && req && !ack_q && req_we && gap_zero;
  assign phase_done = (ph_q != PH_IDLE) && phase_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ack_q <= 1'b0;
    end else begin
      ack_q <= phase_done;
      if (start_rd)        ph_q <= PH_READ;
      else if (start_wr)   ph_q <= PH_WRITE;
      else if (phase_done) ph_q <= PH_IDLE;
    end
  end

  assign phase = ph_q;
  assign ack   = ack_q;
endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_sample,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (capture) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_sample) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_AA_NS       = 120,
  parameter int unsigned T_OE_NS       = 60,
  parameter int unsigned T_WP_NS       = 85,
  parameter int unsigned T_CW_NS       = 100,
  parameter int unsigned T_AW_NS       = 100,
  parameter int unsigned T_DW_NS       = 50,
  parameter int unsigned T_FLOAT_NS    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned N_RD  = max2(cycles_for(T_AA_NS, CLK_PERIOD_NS),
                                       cycles_for(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned N_WR  = max2(max2(cycles_for(T_WP_NS, CLK_PERIOD_NS),
                                            cycles_for(T_CW_NS, CLK_PERIOD_NS)),
                                       max2(cycles_for(T_AW_NS, CLK_PERIOD_NS),
                                            cycles_for(T_DW_NS, CLK_PERIOD_NS)));
  localparam int unsigned N_FLT = cycles_for(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_W = cnt_bits(max2(max2(N_RD, N_WR), N_FLT));

  // Named internal events, also observed by the bound checker.
  phase_e     phase;
  logic       start_rd, start_wr, phase_done;
  logic       phase_zero, gap_zero;
  logic       start_any, rd_done;
  logic [CNT_W-1:0] phase_len;

  assign start_any = start_rd | start_wr;
  assign rd_done   = phase_done && (phase == PH_READ);
  assign phase_len = start_rd ? CNT_W'(N_RD - 1) : CNT_W'(N_WR - 1);

  sramc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .phase_zero (phase_zero),
    .gap_zero   (gap_zero),
    .phase      (phase),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .phase_done (phase_done),
    .ack        (ack)
  );

  sramc_downctr #(.W(CNT_W)) u_phase_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_any),
    .load_val (phase_len),
    .is_zero  (phase_zero)
  );

  sramc_downctr #(.W(CNT_W)) u_gap_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_done),
    .load_val (CNT_W'(N_FLT)),
    .is_zero  (gap_zero)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (start_any),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_sample (rd_done),
    .dq_in     (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (rdata)
  );

  // Strobes decode straight from the registered phase.
  assign mem_cs1_n = (phase == PH_IDLE);
  assign mem_cs2   = (phase != PH_IDLE);
  assign mem_we_n  = (phase != PH_WRITE);
  assign mem_oe_n  = (phase != PH_READ);
  assign mem_dq_oe = (phase == PH_WRITE);
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned N_RD   = 15,
  parameter int unsigned N_WR   = 13,
  parameter int unsigned N_FLT  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              cs1_n,
  input logic              cs2,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              phase_done,
  input logic [ADDR_W-1:0] addr
);
  logic [15:0] rd_len, wr_len, flt_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_len  <= '0;
      wr_len  <= '0;
      flt_cnt <= 16'(N_FLT);
    end else begin
      rd_len  <= !oe_n ? rd_len + 1'b1 : '0;
      wr_len  <= !we_n ? wr_len + 1'b1 : '0;
      if (!oe_n)                     flt_cnt <= '0;
      else if (flt_cnt < 16'(N_FLT)) flt_cnt <= flt_cnt + 1'b1;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_n |-> (!cs2 && we_n && oe_n && !dq_oe)); // R1
  AST_RD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (rd_len == 16'(N_RD))); // R2
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R2
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (wr_len == 16'(N_WR))); // R4
  AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == !we_n); // R5
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R6
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> (ack && cs1_n)); // R6
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (flt_cnt >= 16'(N_FLT))); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs1_n && $past(!cs1_n)) |-> $stable(addr)); // R8
endmodule

bind sram_async_ctrl sramc_checker #(
  .ADDR_W (ADDR_W),
  .N_RD   (N_RD),
  .N_WR   (N_WR),
  .N_FLT  (N_FLT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .cs1_n      (mem_cs1_n),
  .cs2        (mem_cs2),
  .we_n       (mem_we_n),
  .oe_n       (mem_oe_n),
  .dq_oe      (mem_dq_oe),
  .phase_done (phase_done),
  .addr       (mem_addr)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
  localparam int PER = 8;

  function automatic int ns_up(int ns);
    return (ns / PER) + ((ns % PER) != 0 ? 1 : 0);
  endfunction

  localparam int EXP_RD  = (ns_up(120) > ns_up(60)) ? ns_up(120) : ns_up(60);
  localparam int EXP_WR  = ns_up(100);   // largest of 85, 100, 100, 50 ns
  localparam int EXP_FL  = ns_up(40);
  localparam int EXP_RW_GAP = (EXP_FL + 1 > 2) ? EXP_FL + 1 : 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ack;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #4 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [16:0] addr_for(int i);
    return 17'((((i * 37) & 'h7FF) << 6) | (i & 'h3F));
  endfunction

  function automatic logic [7:0] data_for(logic [16:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h3C + {7'd0, a[16]};
  endfunction

  // Memory model, indexed by the low six address bits.
  logic [7:0] shadow [64];
  int rd_run = 0;
  always_comb begin
    if (!mem_oe_n && !mem_cs1_n && rd_run == EXP_RD) mem_dq_in = shadow[mem_addr[5:0]];
    else                                             mem_dq_in = 8'hA5 ^ shadow[mem_addr[5:0]];
  end

  // Driver-side expectations.
  logic        drv_we = 1'b0, drv_chained = 1'b0;
  logic [16:0] drv_addr = '0;
  logic [7:0]  drv_data = '0;

  // Monitor state.
  int          run_kind = 0, prev_kind = 0, run_len = 0, idle_run = 0;
  logic        run_chained = 1'b0;
  logic [16:0] run_addr = '0;
  logic [7:0]  run_data = '0, last_dq = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R1",
          {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 6'b101100);
      run_kind = 0; prev_kind = 0; idle_run = 0; rd_run = 0;
    end else if (mem_cs1_n) begin
      chk(!mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1",
          {mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
      if (run_kind != 0) begin
        chk(run_len == (run_kind == 1 ? EXP_RD : EXP_WR), run_kind == 1 ? "R2" : "R4",
            run_len, run_kind == 1 ? EXP_RD : EXP_WR);
        chk(ack == 1'b1, "R6", ack, 1);
        if (run_kind == 1) chk(rdata == data_for(run_addr), "R3", rdata, data_for(run_addr));
        else               shadow[run_addr[5:0]] = last_dq;
        prev_kind = run_kind;
        run_kind  = 0;
        idle_run  = 0;
      end else begin
        chk(ack == 1'b0, "R6", ack, 0);
      end
      idle_run++;
      rd_run = 0;
    end else begin
      if (run_kind == 0) begin
        run_kind    = mem_oe_n ? 2 : 1;
        run_len     = 0;
        run_addr    = drv_addr;
        run_data    = drv_data;
        run_chained = drv_chained;
        chk(run_kind == (drv_we ? 2 : 1), "R2", run_kind, drv_we ? 2 : 1);
        if (run_chained && prev_kind != 0) begin
          if (prev_kind == 1 && run_kind == 2)
            chk(idle_run == EXP_RW_GAP, "R7", idle_run, EXP_RW_GAP);
          else
            chk(idle_run == 2, "R6", idle_run, 2);
        end
      end
      run_len++;
      chk(ack == 1'b0, "R6", ack, 0);
      chk(mem_addr == run_addr, "R8", mem_addr, run_addr);
      if (run_kind == 1) begin
        rd_run = run_len;
        chk(mem_cs2 && mem_we_n && !mem_oe_n && !mem_dq_oe, "R2",
            {mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1100);
      end else begin
        chk(mem_cs2 && !mem_we_n && mem_oe_n, "R4", {mem_cs2, mem_we_n, mem_oe_n}, 3'b101);
        chk(mem_dq_oe == 1'b1, "R5", mem_dq_oe, 1);
        chk(mem_dq_out == run_data, "R8", mem_dq_out, run_data);
        last_dq = mem_dq_out;
      end
    end
  end

  // Called on a falling edge; returns on the falling edge of the acknowledge cycle.
  task automatic txn(bit we, logic [16:0] a);
    drv_chained = req;
    drv_we   = we;
    drv_addr = a;
    drv_data = data_for(a);
    req_we    = we;
    req_addr  = a;
    req_wdata = data_for(a);
    req       = 1'b1;
    do @(negedge clk); while (mem_cs1_n);
    req_addr  = ~a;                 // R8: scrambled while active
    req_wdata = ~data_for(a);
    do @(negedge clk); while (!ack);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Chained writes, then chained reads.
    for (int i = 0; i < 32; i++) txn(1'b1, addr_for(i));
    for (int i = 0; i < 32; i++) txn(1'b0, addr_for(i));
    // Mixed orderings: write->read, read->read, read->write.
    for (int i = 32; i < 48; i++) begin
      txn(1'b1, addr_for(i));
      txn(1'b0, addr_for(i));
      txn(1'b0, addr_for(i - 32));
      txn(1'b1, addr_for(i + 16));
    end
    for (int i = 48; i < 64; i++) txn(1'b0, addr_for(i));
    // Isolated transactions after idle periods.
    req = 1'b0;
    repeat (5) @(negedge clk);
    txn(1'b0, addr_for(7));
    req = 1'b0;
    repeat (9) @(negedge clk);
    txn(1'b1, addr_for(7));
    txn(1'b0, addr_for(7));
    req = 1'b0;
    repeat (6) @(negedge clk);
    chk(rdata == data_for(addr_for(7)), "R3", rdata, data_for(addr_for(7)));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule